// File: doc/BRIEF.md
# Crosspoint Configuration Register Bank

This block is the control plane of a four-by-four digital crosspoint. A small parallel bus, made of a 4-bit address, a shared 4-bit bidirectional data bus and separate write and read strobes, loads and reads back the switch settings. Each output has a source index, an enable bit and a 4-bit drive-level code. Each input has a 4-bit equalization code. The represented drive level is 2 + 2 × code in milliamp units, but the block keeps and exports only the raw codes.

The two upper address bits choose the kind of setting and the two lower bits choose the port. One address space is set aside for broadcast writes, which put the same value into every port at once. The block also switches four 1-bit lanes from inputs to outputs using the stored routing, and forces disabled outputs low. A static mode pin selects a paired 2×2 layout in place of the full 4×4 decode. In that layout a single write sets all four enables from the address word and all four pair-local selects from the data word.

Top module: `xbar_cfg_bank`

## Requirements
- R1: After reset every output is disabled (`sig_out` = 0), output i is routed to input i, and all drive-level and equalization codes are 0.
- R2: In 4×4 mode a write to address 00pp sets the source of output pp to data[1:0] and its enable to data[2] (1 = enabled). A read of 00pp returns {0, enable, source}, so data[3] reads back as 0.
- R3: In 4×4 mode a write to address 01pp stores data[3:0] as the drive code of output pp. The code appears on `drv_code[4*pp+3:4*pp]` and a read of 01pp returns it.
- R4: In 4×4 mode a write to address 11pp stores data[3:0] as the equalization code of input pp. The code appears on `eq_code[4*pp+3:4*pp]` and a read of 11pp returns it.
- R5: A write to address 1000 sets the source of all four outputs to data[1:0] and their enables to data[2].
- R6: A write to address 1001 stores data[3:0] as the drive code of all four outputs.
- R7: A write to address 1011 stores data[3:0] as the equalization code of all four inputs.
- R8: A write to address 1010 changes no setting. A read from any address 10xx returns 0000.
- R9: The block drives the data bus only while `rd_en` is high and `wr_en` is low. At all other times the bus carries the value the external driver puts on it.
- R10: Each output, combinationally, equals the input its stored source selects when it is enabled, and 0 when it is disabled.
- R11: In dual 2×2 mode (`mode_dual2x2` = 1), any write sets the enable of output i to address bit i and its select to data bit i. Outputs 0 and 1 take input 0 or 1, and outputs 2 and 3 take input 2 or 3. Drive and equalization codes are left unchanged.
- R12: In dual 2×2 mode a read returns, in bit i, the select bit of output i, and routing keeps each output within its pair.
- R13: Writes take effect on the rising clock edge on which `wr_en` is high. Reads are combinational from the stored state.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_dual2x2 | input | 1 | Static layout select, 1 = paired 2×2 |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| rd_en | input | 1 | Read strobe, enables the bus driver |
| addr | input | 4 | Setting type [3:2] and port [1:0], or enable mask in 2×2 mode |
| cfg_data | inout | 4 | Shared write and readback data |
| sig_in | input | 4 | Lanes entering the crosspoint |
| sig_out | output | 4 | Routed lanes, 0 when disabled |
| drv_code | output | 16 | Drive-level codes, 4 bits per output |
| eq_code | output | 16 | Equalization codes, 4 bits per input |

## Verification
The hardest state to reach from the ports is a mix of per-port and broadcast history in which one port differs from the others. A dual-mode write must then be shown to leave those differing drive and equalization codes untouched. The stimulus runs a long seeded random mix of addresses across all four spaces, reserved code included, with a lane pattern checked after every operation. It then switches to the paired layout without a reset, so the pair-local routing is exercised on top of whatever full-range sources the random phase left behind.

// File: rtl/xbar_cfg_pkg.sv
package xbar_cfg_pkg;

   // Setting spaces selected by the two upper address bits
   localparam logic [1:0] SP_CONN  = 2'b00;
   localparam logic [1:0] SP_DRIVE = 2'b01;
   localparam logic [1:0] SP_BCAST = 2'b10;
   localparam logic [1:0] SP_EQ    = 2'b11;

   // Sub-codes inside the broadcast space
   localparam int unsigned BC_CONN  = 0;
   localparam int unsigned BC_DRIVE = 1;
   localparam int unsigned BC_RSVD  = 2;
   localparam int unsigned BC_EQ    = 3;

   typedef enum logic [1:0] {
      RD_NONE,
      RD_CONN,
      RD_DRIVE,
      RD_EQ
   } rd_kind_e;

endpackage

// File: rtl/xbar_cfg_decode.sv
module xbar_cfg_decode
   import xbar_cfg_pkg::*;
#(
   parameter int unsigned PORT_W = 2,
   localparam int unsigned N_PORTS = 1 << PORT_W,
   localparam int unsigned ADDR_W = PORT_W + 2
) (
   input  logic                wr_en,
   input  logic                mode_dual,
   input  logic [ADDR_W-1:0]   addr,
   output logic [N_PORTS-1:0]  conn_we,
   output logic [N_PORTS-1:0]  drv_we,
   output logic [N_PORTS-1:0]  eq_we,
   output logic                dual_we,
   output rd_kind_e            rd_kind
);

   logic [1:0]        space;
   logic [PORT_W-1:0] port;

   assign space   = addr[ADDR_W-1 -: 2];
   assign port    = addr[PORT_W-1:0];
   assign dual_we = wr_en & mode_dual;

   always_comb begin
      conn_we = '0;
      drv_we  = '0;
      eq_we   = '0;
      if (wr_en && !mode_dual) begin
         case (space)
            SP_CONN:  conn_we[port] = 1'b1;
            SP_DRIVE: drv_we[port]  = 1'b1;
            SP_EQ:    eq_we[port]   = 1'b1;
            default: begin
               if (port == PORT_W'(BC_CONN))       conn_we = '1;
               else if (port == PORT_W'(BC_DRIVE)) drv_we  = '1;
               else if (port == PORT_W'(BC_EQ))    eq_we   = '1;
            end
         endcase
      end
   end

   always_comb begin
      case (space)
         SP_CONN:  rd_kind = RD_CONN;
         SP_DRIVE: rd_kind = RD_DRIVE;
         SP_EQ:    rd_kind = RD_EQ;
         default:  rd_kind = RD_NONE;
      endcase
   end

endmodule

// File: rtl/xbar_cfg_regs.sv
module xbar_cfg_regs #(
   parameter int unsigned PORT_W = 2,
   parameter int unsigned CODE_W = 4,
   localparam int unsigned N_PORTS = 1 << PORT_W,
   localparam int unsigned ADDR_W = PORT_W + 2
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [N_PORTS-1:0]               conn_we,
   input  logic [N_PORTS-1:0]               drv_we,
   input  logic [N_PORTS-1:0]               eq_we,
   input  logic                             dual_we,
   input  logic [ADDR_W-1:0]                addr,
   input  logic [CODE_W-1:0]                wdata,
   output logic [N_PORTS-1:0][PORT_W-1:0]   src_q,
   output logic [N_PORTS-1:0]               en_q,
   output logic [N_PORTS-1:0][CODE_W-1:0]   drv_q,
   output logic [N_PORTS-1:0][CODE_W-1:0]   eq_q
);

   for (genvar i = 0; i < N_PORTS; i++) begin : g_port
      localparam logic [PORT_W-1:0] HOME      = PORT_W'(i);
      localparam logic [PORT_W-1:0] PAIR_BASE = PORT_W'((i / 2) * 2);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            src_q[i] <= HOME;
            en_q[i]  <= 1'b0;
         end else if (dual_we) begin
            src_q[i] <= PAIR_BASE | PORT_W'(wdata[i]);
            en_q[i]  <= addr[i];
         end else if (conn_we[i]) begin
            src_q[i] <= wdata[PORT_W-1:0];
            en_q[i]  <= wdata[PORT_W];
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            drv_q[i] <= '0;
         end else if (drv_we[i]) begin
            drv_q[i] <= wdata;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            eq_q[i] <= '0;
         end else if (eq_we[i]) begin
            eq_q[i] <= wdata;
         end
      end
   end

endmodule

// File: rtl/xbar_cfg_route.sv
module xbar_cfg_route #(
   parameter int unsigned PORT_W = 2,
   localparam int unsigned N_PORTS = 1 << PORT_W
) (
   input  logic                           mode_dual,
   input  logic [N_PORTS-1:0]             sig_in,
   input  logic [N_PORTS-1:0][PORT_W-1:0] src_q,
   input  logic [N_PORTS-1:0]             en_q,
   output logic [N_PORTS-1:0]             sig_out
);

   for (genvar i = 0; i < N_PORTS; i++) begin : g_lane
      localparam logic [PORT_W-1:0] PAIR_BASE = PORT_W'((i / 2) * 2);
      logic [PORT_W-1:0] sel;

      assign sel        = mode_dual ? (PAIR_BASE | PORT_W'(src_q[i][0])) : src_q[i];
      assign sig_out[i] = en_q[i] & sig_in[sel];
   end

endmodule

// File: rtl/xbar_cfg_bank.sv
module xbar_cfg_bank
   import xbar_cfg_pkg::*;
#(
   parameter int unsigned PORT_W = 2,
   parameter int unsigned CODE_W = 4,
   localparam int unsigned N_PORTS = 1 << PORT_W,
   localparam int unsigned ADDR_W = PORT_W + 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        mode_dual2x2,
   input  logic                        wr_en,
   input  logic                        rd_en,
   input  logic [ADDR_W-1:0]           addr,
   inout  wire  [CODE_W-1:0]           cfg_data,
   input  logic [N_PORTS-1:0]          sig_in,
   output logic [N_PORTS-1:0]          sig_out,
   output logic [N_PORTS*CODE_W-1:0]   drv_code,
   output logic [N_PORTS*CODE_W-1:0]   eq_code
);

   // Elaboration-time parameter checks
   if (CODE_W < PORT_W + 1) begin : g_bad_code_w
      $error("CODE_W must hold a source index plus an enable bit");
   end
   if (CODE_W < N_PORTS || ADDR_W < N_PORTS) begin : g_bad_dual
      $error("paired layout needs one address bit and one data bit per output");
   end

   logic [N_PORTS-1:0]               conn_we, drv_we, eq_we;
   logic                             dual_we;
   rd_kind_e                         rd_kind;
   logic [N_PORTS-1:0][PORT_W-1:0]   src_q;
   logic [N_PORTS-1:0]               out_en;
   logic [N_PORTS-1:0][CODE_W-1:0]   drv_q, eq_q;
   logic [CODE_W-1:0]                wr_word;
   logic [CODE_W-1:0]                rd_word;
   logic                             bus_oe;
   logic [PORT_W-1:0]                port;

   assign wr_word = cfg_data;
   assign port    = addr[PORT_W-1:0];

   xbar_cfg_decode #(.PORT_W(PORT_W)) i_decode (
      .wr_en     (wr_en),
      .mode_dual (mode_dual2x2),
      .addr      (addr),
      .conn_we   (conn_we),
      .drv_we    (drv_we),
      .eq_we     (eq_we),
      .dual_we   (dual_we),
      .rd_kind   (rd_kind)
   );

   xbar_cfg_regs #(.PORT_W(PORT_W), .CODE_W(CODE_W)) i_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .conn_we (conn_we),
      .drv_we  (drv_we),
      .eq_we   (eq_we),
      .dual_we (dual_we),
      .addr    (addr),
      .wdata   (wr_word),
      .src_q   (src_q),
      .en_q    (out_en),
      .drv_q   (drv_q),
      .eq_q    (eq_q)
   );

   xbar_cfg_route #(.PORT_W(PORT_W)) i_route (
      .mode_dual (mode_dual2x2),
      .sig_in    (sig_in),
      .src_q     (src_q),
      .en_q      (out_en),
      .sig_out   (sig_out)
   );

   // Readback word selection
   always_comb begin
      rd_word = '0;
      if (mode_dual2x2) begin
         for (int i = 0; i < N_PORTS; i++) rd_word[i] = src_q[i][0];
      end else begin
         case (rd_kind)
            RD_CONN:  rd_word[PORT_W:0] = {out_en[port], src_q[port]};
            RD_DRIVE: rd_word = drv_q[port];
            RD_EQ:    rd_word = eq_q[port];
            default:  rd_word = '0;
         endcase
      end
   end

   assign bus_oe   = rd_en & ~wr_en;
   assign cfg_data = bus_oe ? rd_word : {CODE_W{1'bz}};
   assign drv_code = drv_q;
   assign eq_code  = eq_q;

endmodule

// File: rtl/xbar_cfg_chk.sv
module xbar_cfg_chk #(
   parameter int unsigned PORT_W = 2,
   parameter int unsigned CODE_W = 4,
   localparam int unsigned N_PORTS = 1 << PORT_W,
   localparam int unsigned ADDR_W = PORT_W + 2
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        mode_dual2x2,
   input logic                        wr_en,
   input logic                        rd_en,
   input logic [ADDR_W-1:0]           addr,
   input logic [CODE_W-1:0]           wr_word,
   input logic [CODE_W-1:0]           rd_word,
   input logic                        bus_oe,
   input logic [N_PORTS-1:0]          out_en,
   input logic [N_PORTS-1:0]          sig_out,
   input logic [N_PORTS*CODE_W-1:0]   drv_code,
   input logic [N_PORTS*CODE_W-1:0]   eq_code
);

   localparam logic [ADDR_W-1:0] A_BC_DRIVE = {2'b10, PORT_W'(1)};
   localparam logic [ADDR_W-1:0] A_BC_RSVD  = {2'b10, PORT_W'(2)};
   localparam logic [ADDR_W-1:0] A_BC_EQ    = {2'b10, PORT_W'(3)};

   p_disabled_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (sig_out & ~out_en) == '0);

   p_bus_float_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |-> !bus_oe);

   p_bcast_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en && !mode_dual2x2 && addr[ADDR_W-1 -: 2] == 2'b10) |-> rd_word == '0);

   p_reserved_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !mode_dual2x2 && addr == A_BC_RSVD)
      |=> ($stable(drv_code) && $stable(eq_code) && $stable(out_en)));

   p_bcast_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !mode_dual2x2 && addr == A_BC_DRIVE)
      |=> drv_code == {N_PORTS{$past(wr_word)}});

   p_bcast_eq_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !mode_dual2x2 && addr == A_BC_EQ)
      |=> eq_code == {N_PORTS{$past(wr_word)}});

   p_dual_enable_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && mode_dual2x2)
      |=> (out_en == $past(addr[N_PORTS-1:0]) && $stable(drv_code) && $stable(eq_code)));

endmodule

bind xbar_cfg_bank xbar_cfg_chk #(.PORT_W(PORT_W), .CODE_W(CODE_W)) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .mode_dual2x2 (mode_dual2x2),
   .wr_en        (wr_en),
   .rd_en        (rd_en),
   .addr         (addr),
   .wr_word      (wr_word),
   .rd_word      (rd_word),
   .bus_oe       (bus_oe),
   .out_en       (out_en),
   .sig_out      (sig_out),
   .drv_code     (drv_code),
   .eq_code      (eq_code)
);

// File: tb/test_xbar_cfg_bank.sv
module test_xbar_cfg_bank;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_dual2x2 = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [3:0]  addr = '0;
   logic [3:0]  tb_drv = '0;
   logic        tb_oe = 1'b0;
   wire  [3:0]  cfg_data;
   logic [3:0]  sig_in = '0;
   logic [3:0]  sig_out;
   logic [15:0] drv_code, eq_code;

   int n_chk = 0;
   int n_fail = 0;

   // bench model of the stored settings
   logic [1:0] m_src [4];
   logic       m_en  [4];
   logic [3:0] m_drv [4];
   logic [3:0] m_eq  [4];

   assign cfg_data = tb_oe ? tb_drv : 4'bzzzz;

   always #2.5 clk = ~clk;

   xbar_cfg_bank i_xbar_cfg_bank (
      .clk(clk), .rst_n(rst_n), .mode_dual2x2(mode_dual2x2),
      .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .cfg_data(cfg_data),
      .sig_in(sig_in), .sig_out(sig_out), .drv_code(drv_code), .eq_code(eq_code)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic void model_reset();
      for (int i = 0; i < 4; i++) begin
         m_src[i] = 2'(i); m_en[i] = 1'b0; m_drv[i] = '0; m_eq[i] = '0;
      end
   endfunction

   function automatic void model_write(input logic [3:0] a, input logic [3:0] d, input logic dual);
      if (dual) begin
         for (int i = 0; i < 4; i++) begin
            m_en[i]  = a[i];
            m_src[i] = {i[1], d[i]};
         end
      end else begin
         case (a[3:2])
            2'b00: begin m_src[a[1:0]] = d[1:0]; m_en[a[1:0]] = d[2]; end
            2'b01: m_drv[a[1:0]] = d;
            2'b11: m_eq[a[1:0]]  = d;
            default: begin
               for (int i = 0; i < 4; i++) begin
                  if (a[1:0] == 2'd0) begin m_src[i] = d[1:0]; m_en[i] = d[2]; end
                  if (a[1:0] == 2'd1) m_drv[i] = d;
                  if (a[1:0] == 2'd3) m_eq[i] = d;
               end
            end
         endcase
      end
   endfunction

   function automatic logic [3:0] model_read(input logic [3:0] a, input logic dual);
      logic [3:0] r;
      r = '0;
      if (dual) begin
         for (int i = 0; i < 4; i++) r[i] = m_src[i][0];
      end else begin
         case (a[3:2])
            2'b00: r = {1'b0, m_en[a[1:0]], m_src[a[1:0]]};
            2'b01: r = m_drv[a[1:0]];
            2'b11: r = m_eq[a[1:0]];
            default: r = '0;
         endcase
      end
      return r;
   endfunction

   function automatic logic [3:0] model_route(input logic [3:0] in, input logic dual);
      logic [3:0] o;
      logic [1:0] s;
      for (int i = 0; i < 4; i++) begin
         s = dual ? {i[1], m_src[i][0]} : m_src[i];
         o[i] = m_en[i] & in[s];
      end
      return o;
   endfunction

   function automatic logic [15:0] pack_drv();
      return {m_drv[3], m_drv[2], m_drv[1], m_drv[0]};
   endfunction

   function automatic logic [15:0] pack_eq();
      return {m_eq[3], m_eq[2], m_eq[1], m_eq[0]};
   endfunction

   function automatic string req_of(input logic [3:0] a, input logic dual);
      if (dual) return "R11/R12";
      case (a)
         4'b1000: return "R5";
         4'b1001: return "R6";
         4'b1010: return "R8";
         4'b1011: return "R7";
         default: ;
      endcase
      case (a[3:2])
         2'b00: return "R2";
         2'b01: return "R3";
         default: return "R4";
      endcase
   endfunction

   // write applied on the next rising edge (R13)
   task automatic do_write(input logic [3:0] a, input logic [3:0] d);
      @(negedge clk);
      rd_en = 1'b0; wr_en = 1'b1; addr = a; tb_drv = d; tb_oe = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; tb_oe = 1'b0;
      model_write(a, d, mode_dual2x2);
   endtask

   task automatic do_read(input logic [3:0] a, input string req);
      @(negedge clk);
      wr_en = 1'b0; tb_oe = 1'b0; rd_en = 1'b1; addr = a;
      #1;
      chk(req, 16'(cfg_data), 16'(model_read(a, mode_dual2x2)));
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic check_lanes(input logic [3:0] in, input string req);
      @(negedge clk);
      sig_in = in;
      #1;
      chk(req, 16'(sig_out), 16'(model_route(in, mode_dual2x2)));
   endtask

   task automatic check_codes(input string req);
      #0.1;
      chk(req, drv_code, pack_drv());
      chk(req, eq_code, pack_eq());
   endtask

   task automatic finish_run();
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      logic [3:0] a, d;
      void'($urandom(32'h5eed_1234));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      check_lanes(4'hF, "R1 lanes after reset");
      check_codes("R1 codes after reset");
      for (int p = 0; p < 4; p++) do_read({2'b00, 2'(p)}, "R1 reset routing");

      // R9 bus carries the external value when the block is not reading
      @(negedge clk);
      tb_oe = 1'b1; tb_drv = 4'hA; rd_en = 1'b0; addr = 4'h0; #1;
      chk("R9 bus idle", 16'(cfg_data), 16'hA);
      rd_en = 1'b1; wr_en = 1'b1; addr = 4'b1001; tb_drv = 4'h6; #1;
      chk("R9 bus during write with read strobe", 16'(cfg_data), 16'h6);
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0; tb_oe = 1'b0;
      model_write(4'b1001, 4'h6, 1'b0);
      check_codes("R6 broadcast drive with read strobe high");

      // R2 per-port routing, R10 lanes
      do_write(4'b0000, 4'b0111);
      do_write(4'b0001, 4'b0110);
      do_write(4'b0010, 4'b0001);
      do_write(4'b0011, 4'b0100);
      do_read(4'b0000, "R2 conn readback bit3 zero");
      check_lanes(4'b1000, "R10 lanes pattern a");
      check_lanes(4'b0100, "R10 lanes pattern b");

      // R8 reserved broadcast write and broadcast reads
      do_write(4'b1011, 4'h9);
      do_write(4'b1010, 4'hF);
      check_codes("R8 reserved write ignored");
      check_lanes(4'hF, "R8 reserved write keeps routing");
      for (int p = 0; p < 4; p++) do_read({2'b10, 2'(p)}, "R8 broadcast read zero");

      // R5 broadcast connectivity
      do_write(4'b1000, 4'b0110);
      check_lanes(4'b0100, "R5 broadcast routing");
      do_read(4'b0011, "R5 broadcast readback");

      // random 4x4 traffic (R2..R8, R10, R13)
      for (int k = 0; k < 400; k++) begin
         a = 4'($urandom_range(0, 15));
         d = 4'($urandom_range(0, 15));
         do_write(a, d);
         check_codes(req_of(a, 1'b0));
         do_read(4'($urandom_range(0, 15)), req_of(a, 1'b0));
         check_lanes(4'($urandom_range(0, 15)), "R10 random lanes");
      end

      // dual 2x2 layout on top of random history (R11, R12)
      mode_dual2x2 = 1'b1;
      check_lanes(4'hF, "R12 pair routing before dual write");
      do_write(4'b1111, 4'b1010);
      check_codes("R11 codes untouched");
      check_lanes(4'b0110, "R11 dual routing");
      do_read(4'b0000, "R12 dual readback");
      for (int k = 0; k < 200; k++) begin
         do_write(4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)));
         check_codes("R11 random dual codes");
         do_read(4'($urandom_range(0, 15)), "R12 random dual readback");
         check_lanes(4'($urandom_range(0, 15)), "R12 random dual lanes");
      end

      // back to 4x4: dual-written sources read back in full
      mode_dual2x2 = 1'b0;
      for (int p = 0; p < 4; p++) do_read({2'b00, 2'(p)}, "R2 readback after dual");

      // R1 reset again mid-run
      @(negedge clk);
      rst_n = 1'b0;
      model_reset();
      @(negedge clk);
      rst_n = 1'b1;
      check_codes("R1 codes after second reset");
      check_lanes(4'hF, "R1 lanes after second reset");

      finish_run();
   end

endmodule